// File: doc/BRIEF.md
# Single-lane serial flash shift engine

This block is the shifting core of a register-programmed serial flash controller. Software writes 32-bit words into a transmit queue and reads 32-bit words from a receive queue. The engine turns each queued word into 8-bit serial frames, most significant bit first, drives the serial clock and the active-low device selects, and captures one receive byte for every byte it sends. The last captured byte of each entry completes one receive word.

A configuration register sets the clock idle level, the sampling edge, a divider code and the select field. It also chooses between automatic and forced select and between free-running and triggered start. A separate enable register gates every new transfer. Transmit data reaches the queue through four write addresses, so each entry carries 1, 2, 3 or 4 bytes. A short entry comes back as a receive word with its bytes packed at the top end.

Top module: `flash_spi_engine`

## Requirements
- R1: After reset, `spi_cs_n` is all ones and `spi_sclk` is 0. The configuration register reads 0x00003C00 and the enable register reads 0.
- R2: The serial clock runs at the reference clock divided by (2 << code), where code is configuration bits 5:3. Each clock half lasts 2^code reference cycles.
- R3: Configuration bit 1 sets the idle level of `spi_sclk`. Configuration bit 2 selects the sampling edge: 0 samples on the leading edge and changes data on the trailing edge, 1 does the opposite. Bits within a byte go out MSB first.
- R4: A write to 0x1C queues 4 bytes. A write to 0x80, 0x84 or 0x88 queues 1, 2 or 3 bytes. The bytes go out starting at write-data bits 7:0 and then in ascending byte order.
- R5: An entry of n bytes returns one receive word. Its first captured byte sits in byte lane 4-n and its last in lane 3, and the lanes below 4-n read 0. A read of address 0x20 returns the oldest word and removes it.
- R6: While bit 0 of the enable register at 0x14 is 0, no transfer starts: `spi_sclk` shows no edges and `spi_cs_n` stays all ones when select is not forced.
- R7: With configuration bit 15 at 0, shifting begins as soon as the transmit queue holds an entry.
- R8: With configuration bit 15 at 1, queued entries wait until a configuration write carries bit 16 set. That bit always reads back as 0.
- R9: With configuration bit 14 set, `spi_cs_n` equals configuration bits 13:10 at all times. With bit 14 clear, `spi_cs_n` equals that field while entries are being shifted and is all ones otherwise.
- R10: Entries are shifted, and their receive words returned, in the order they were written, with nothing lost up to the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NCS | Active-low device selects |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A queued entry starts one cycle after its write when the engine is idle and start is allowed. Each byte then takes 16·2^code cycles, and the receive word becomes readable one cycle after the final trailing clock half. The bench waits bytes·16·2^code cycles plus a margin before it reads. The serial monitor runs on the falling reference edge, detects each `spi_sclk` transition there and judges the data bit from the value `spi_mosi` held in the cycle before that edge, because the engine changes its output on the same reference edge that ends a bit. Clock-half lengths are measured in reference cycles from a leading edge to the next trailing edge.

// File: rtl/flash_spi_pkg.sv
package flash_spi_pkg;

  localparam logic [7:0] ADR_CFG  = 8'h00;
  localparam logic [7:0] ADR_EN   = 8'h14;
  localparam logic [7:0] ADR_TXW  = 8'h1C;
  localparam logic [7:0] ADR_RXW  = 8'h20;
  localparam logic [7:0] ADR_TXB1 = 8'h80;
  localparam logic [7:0] ADR_TXB2 = 8'h84;
  localparam logic [7:0] ADR_TXB3 = 8'h88;

  localparam logic [31:0] CFG_RESET = 32'h0000_3C00;

  localparam int BIT_CPOL  = 1;
  localparam int BIT_CPHA  = 2;
  localparam int DIV_LSB   = 3;
  localparam int CS_LSB    = 10;
  localparam int BIT_FORCE = 14;
  localparam int BIT_MAN   = 15;
  localparam int BIT_TRIG  = 16;

  typedef struct packed {
    logic [2:0]  nbytes;
    logic [31:0] data;
  } tx_entry_t;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

  // number of bytes a transmit address carries, 0 when not a transmit address
  function automatic logic [2:0] tx_len(input logic [7:0] a);
    case (a)
      ADR_TXB1: return 3'd1;
      ADR_TXB2: return 3'd2;
      ADR_TXB3: return 3'd3;
      ADR_TXW:  return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  // reference cycles per serial clock half
  function automatic logic [7:0] half_cycles(input logic [2:0] code);
    return 8'd1 << code;
  endfunction

  // insert a finished byte at the top lane, older bytes move down
  function automatic logic [31:0] lane_insert(input logic [31:0] w, input logic [7:0] b);
    return {b, w[31:8]};
  endfunction

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= adv(wp_q);
      if (do_pop)  rp_q <= adv(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10

endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import flash_spi_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           rd,
  input  logic [7:0]     addr,
  input  logic [31:0]    wdata,
  input  logic [31:0]    rx_head,
  input  logic           rx_empty,
  output logic [31:0]    rdata,
  output logic           tx_push,
  output tx_entry_t      tx_entry,
  output logic           rx_pop,
  output logic           trig,
  output logic           en,
  output logic           cpol,
  output logic           cpha,
  output logic [2:0]     code,
  output logic           cs_force,
  output logic [NCS-1:0] cs_field,
  output logic           manual
);
  logic [31:0] cfg_q;
  logic        en_q;
  logic        cfg_wr;
  logic [2:0]  len;

  assign cfg_wr = wr && (addr == ADR_CFG);
  assign len    = tx_len(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      en_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q           <= wdata;
        cfg_q[BIT_TRIG] <= 1'b0;
      end
      if (wr && addr == ADR_EN) en_q <= wdata[0];
    end
  end

  assign trig     = cfg_wr && wdata[BIT_TRIG] && wdata[BIT_MAN];
  assign tx_push  = wr && (len != 3'd0);
  assign tx_entry = '{nbytes: len, data: wdata};
  assign rx_pop   = rd && (addr == ADR_RXW) && !rx_empty;

  assign en       = en_q;
  assign cpol     = cfg_q[BIT_CPOL];
  assign cpha     = cfg_q[BIT_CPHA];
  assign code     = cfg_q[DIV_LSB +: 3];
  assign cs_force = cfg_q[BIT_FORCE];
  assign cs_field = cfg_q[CS_LSB +: NCS];
  assign manual   = cfg_q[BIT_MAN];

  always_comb begin
    case (addr)
      ADR_CFG: rdata = cfg_q;
      ADR_EN:  rdata = {31'd0, en_q};
      ADR_RXW: rdata = rx_head;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import flash_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpol,
  input  logic        cpha,
  input  logic [2:0]  code,
  input  logic        go,
  input  tx_entry_t   tx_head,
  input  logic        tx_empty,
  output logic        tx_pop,
  output logic        rx_push,
  output logic [31:0] rx_word,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  eng_state_t  state_q;
  logic [31:0] cur_q, word_q;
  logic [2:0]  left_q, bit_q;
  logic        half_q;
  logic [7:0]  div_q, rxb_q, lim;
  logic        tick, mid_tick, end_tick, byte_done, load;

  assign lim       = half_cycles(code);
  assign busy      = (state_q == ENG_SHIFT);
  assign tick      = busy && (div_q == lim - 8'd1);
  assign mid_tick  = tick && !half_q;
  assign end_tick  = tick && half_q;
  assign byte_done = end_tick && (bit_q == 3'd0);
  assign load      = !busy && go && !tx_empty;
  assign tx_pop    = load;
  assign rx_push   = byte_done && (left_q == 3'd1);
  assign rx_word   = lane_insert(word_q, rxb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cur_q   <= '0;
      word_q  <= '0;
      left_q  <= '0;
      bit_q   <= '0;
      half_q  <= 1'b0;
      div_q   <= '0;
      rxb_q   <= '0;
    end else if (load) begin
      state_q <= ENG_SHIFT;
      cur_q   <= tx_head.data;
      left_q  <= tx_head.nbytes;
      word_q  <= '0;
      bit_q   <= 3'd7;
      half_q  <= 1'b0;
      div_q   <= '0;
    end else if (busy) begin
      div_q <= tick ? 8'd0 : div_q + 8'd1;
      if (mid_tick) begin
        half_q <= 1'b1;
        rxb_q  <= {rxb_q[6:0], miso};
      end
      if (end_tick) begin
        half_q <= 1'b0;
        if (bit_q == 3'd0) begin
          word_q <= lane_insert(word_q, rxb_q);
          cur_q  <= cur_q >> 8;
          bit_q  <= 3'd7;
          left_q <= left_q - 3'd1;
          if (left_q == 3'd1) state_q <= ENG_IDLE;
        end else begin
          bit_q <= bit_q - 3'd1;
        end
      end
    end
  end

  assign mosi = busy ? cur_q[bit_q] : 1'b0;
  assign sclk = busy ? (cpol ^ (cpha ? ~half_q : half_q)) : cpol;

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick) && $stable(cpol) && $stable(cpha)) |-> $stable(sclk)); // R2

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != 3'd0 && left_q <= 3'd4)); // R4

  AST_RX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !busy || $past(load)); // R5

endmodule

// File: rtl/flash_spi_engine.sv
module flash_spi_engine
  import flash_spi_pkg::*;
#(
  parameter int FIFO_DEPTH = 63,
  parameter int NCS        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           spi_sclk,
  output logic [NCS-1:0] spi_cs_n,
  output logic           spi_mosi,
  input  logic           spi_miso
);
  localparam int ENTRY_W = $bits(tx_entry_t);

  tx_entry_t      tx_in, tx_head;
  logic           tx_push, tx_pop, tx_empty;
  logic [31:0]    rx_word, rx_head;
  logic           rx_push, rx_pop, rx_empty;
  logic           trig, en, cpol, cpha, cs_force, manual, busy, go;
  logic [2:0]     code;
  logic [NCS-1:0] cs_field;
  logic           sess_q, trig_pend_q;

  spi_regs #(.NCS(NCS)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .rx_head, .rx_empty, .rdata(reg_rdata), .tx_push, .tx_entry(tx_in), .rx_pop,
    .trig, .en, .cpol, .cpha, .code, .cs_force, .cs_field, .manual
  );

  spi_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .din(tx_in), .pop(tx_pop), .dout(tx_head), .empty(tx_empty)
  );

  spi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_head), .empty(rx_empty)
  );

  assign go = en && (!manual || trig_pend_q);

  spi_shifter u_shift (
    .clk, .rst_n, .cpol, .cpha, .code, .go, .tx_head, .tx_empty, .tx_pop,
    .rx_push, .rx_word, .busy, .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q      <= 1'b0;
      trig_pend_q <= 1'b0;
    end else begin
      if (tx_pop)                                 sess_q <= 1'b1;
      else if (!busy && !(go && !tx_empty))       sess_q <= 1'b0;
      if (trig)                                   trig_pend_q <= 1'b1;
      else if (!busy && tx_empty)                 trig_pend_q <= 1'b0;
    end
  end

  assign spi_cs_n = (cs_force || sess_q) ? cs_field : '1;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy); // R6

  AST_CS_DURING_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (spi_cs_n == cs_field)); // R9

  AST_WAIT_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && !trig_pend_q && !busy) |=> !busy); // R8

endmodule

// File: tb/sim_flash_spi_engine.sv
module sim_flash_spi_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  always #2 clk = ~clk;
  assign spi_miso = spi_mosi;

  flash_spi_engine u0 (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, edge_cnt = 0, lead_t = 0, nbits = 0;
  logic [7:0] exp_q [$];
  logic [7:0] shreg = '0;
  logic m_cpol = 0, m_cpha = 0, m_ignore = 1;
  logic [2:0] m_code = 0;
  logic [3:0] m_field = 4'hF;
  logic prev_sclk = 0, prev_mosi = 0;
  logic [31:0] cfg_cur;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor on the serial pins
  always @(negedge clk) begin
    cyc++;
    if (m_ignore || !rst_n) begin
      prev_sclk = spi_sclk;
    end else if (spi_sclk != prev_sclk) begin
      bit leading;
      edge_cnt++;
      leading = (prev_sclk == m_cpol);
      chk(spi_cs_n == m_field, "R9 select during clock edge", {28'd0, spi_cs_n}, {28'd0, m_field});
      if (leading) lead_t = cyc;
      else chk((cyc - lead_t) == (1 << m_code), "R2 clock half length",
               32'(cyc - lead_t), 32'(1 << m_code));
      if (leading != m_cpha) begin
        shreg = {shreg[6:0], prev_mosi};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) chk(0, "R4 unexpected byte", {24'd0, shreg}, 32'hxx);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, "R3/R4 serial byte", {24'd0, shreg}, {24'd0, e});
          end
        end
      end
    end
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected<%0d", 150000, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_cfg(input bit cpol, input bit cpha, input logic [2:0] code,
                         input bit frc, input logic [3:0] field, input bit man);
    m_ignore = 1;
    cfg_cur = 32'd1 | (32'(cpol) << 1) | (32'(cpha) << 2) | (32'(code) << 3)
            | (32'(field) << 10) | (32'(frc) << 14) | (32'(man) << 15);
    bus_write(8'h00, cfg_cur);
    m_cpol = cpol; m_cpha = cpha; m_code = code; m_field = field;
    repeat (2) @(negedge clk);
    m_ignore = 0;
  endtask

  task automatic send(input int n, input logic [31:0] d);
    logic [7:0] a;
    a = (n == 1) ? 8'h80 : (n == 2) ? 8'h84 : (n == 3) ? 8'h88 : 8'h1C;
    for (int i = 0; i < n; i++) exp_q.push_back(d[8*i +: 8]);
    bus_write(a, d);
  endtask

  function automatic logic [31:0] exp_rx(input int n, input logic [31:0] d);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[8*(4-n+i) +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic wait_bytes(input int n);
    repeat (n * 16 * (1 << m_code) + 30) @(negedge clk);
  endtask

  task automatic rx_check(input int n, input logic [31:0] d, input string tag);
    logic [31:0] got;
    bus_read(8'h20, got);
    chk(got == exp_rx(n, d), tag, got, exp_rx(n, d));
  endtask

  initial begin
    logic [31:0] rv;
    int e0;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 4'hF, "R1 reset select", {28'd0, spi_cs_n}, 32'hF);
    chk(spi_sclk == 1'b0, "R1 reset clock", {31'd0, spi_sclk}, 32'd0);
    rst_n = 1'b1;
    bus_read(8'h00, rv);
    chk(rv == 32'h0000_3C00, "R1 config reset value", rv, 32'h0000_3C00);
    bus_read(8'h14, rv);
    chk(rv == 32'd0, "R1 enable reset value", rv, 32'd0);

    // R6: disabled engine holds a queued word
    set_cfg(0, 0, 3'd0, 0, 4'hE, 0);
    e0 = edge_cnt;
    send(4, 32'hA1B2_C3D4);
    repeat (100) @(negedge clk);
    chk(edge_cnt == e0, "R6 no edges while disabled", 32'(edge_cnt), 32'(e0));
    chk(spi_cs_n == 4'hF, "R6 select idle while disabled", {28'd0, spi_cs_n}, 32'hF);
    bus_write(8'h14, 32'd1);
    wait_bytes(4);
    rx_check(4, 32'hA1B2_C3D4, "R7 auto start full word");
    chk(spi_cs_n == 4'hF, "R9 select released after queue drains", {28'd0, spi_cs_n}, 32'hF);

    // R4/R5 partial entries
    send(1, 32'h0000_00AB); wait_bytes(1);
    rx_check(1, 32'h0000_00AB, "R5 one byte packed at top");
    send(2, 32'h0000_CDEF); wait_bytes(2);
    rx_check(2, 32'h0000_CDEF, "R5 two bytes packed at top");
    send(3, 32'h0012_3456); wait_bytes(3);
    rx_check(3, 32'h0012_3456, "R5 three bytes packed at top");

    // R2/R3 other modes and dividers
    set_cfg(1, 1, 3'd2, 0, 4'hB, 0);
    chk(spi_sclk == 1'b1, "R3 idle level high", {31'd0, spi_sclk}, 32'd1);
    send(4, 32'h5A3C_96F0); wait_bytes(4);
    rx_check(4, 32'h5A3C_96F0, "R3 mode 3 loopback");
    set_cfg(0, 1, 3'd1, 0, 4'h7, 0);
    send(3, 32'h00C3_81E7); wait_bytes(3);
    rx_check(3, 32'h00C3_81E7, "R3 mode 1 loopback");
    set_cfg(1, 0, 3'd3, 0, 4'hE, 0);
    send(4, 32'h0F1E_2D3C); wait_bytes(4);
    rx_check(4, 32'h0F1E_2D3C, "R2 divider code 3 loopback");

    // R10 ordering
    set_cfg(0, 0, 3'd0, 0, 4'hE, 0);
    send(4, 32'h1111_2222); send(4, 32'h3333_4444); send(2, 32'h0000_5566);
    wait_bytes(10);
    rx_check(4, 32'h1111_2222, "R10 first word");
    rx_check(4, 32'h3333_4444, "R10 second word");
    rx_check(2, 32'h0000_5566, "R10 third word");

    // R9 forced select
    set_cfg(0, 0, 3'd0, 1, 4'hD, 0);
    chk(spi_cs_n == 4'hD, "R9 forced select idle", {28'd0, spi_cs_n}, 32'hD);
    send(1, 32'h0000_0096); wait_bytes(1);
    chk(spi_cs_n == 4'hD, "R9 forced select after transfer", {28'd0, spi_cs_n}, 32'hD);
    rx_check(1, 32'h0000_0096, "R9 forced select data");
    set_cfg(0, 0, 3'd0, 0, 4'hD, 0);
    chk(spi_cs_n == 4'hF, "R9 automatic select idle", {28'd0, spi_cs_n}, 32'hF);

    // R8 triggered start
    set_cfg(0, 0, 3'd1, 0, 4'hE, 1);
    e0 = edge_cnt;
    send(4, 32'hDEAD_BEEF);
    repeat (150) @(negedge clk);
    chk(edge_cnt == e0, "R8 held until trigger", 32'(edge_cnt), 32'(e0));
    bus_write(8'h00, cfg_cur | 32'h0001_0000);
    bus_read(8'h00, rv);
    chk(rv[16] == 1'b0, "R8 trigger bit reads 0", {31'd0, rv[16]}, 32'd0);
    wait_bytes(4);
    rx_check(4, 32'hDEAD_BEEF, "R8 triggered word");

    chk(exp_q.size() == 0, "R4 all queued bytes seen", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule